// File: doc/BRIEF.md
# Register-Mapped Sampling Converter Controller

This block sits between a simple processor bus and a successive-approximation converter. Software selects an input channel, programs a clock divider and a result width, and sets a start bit. The controller runs one conversion at the divided rate, latches the result, raises an interrupt and clears the start bit by itself. Software then reads the result and writes the acknowledge register to drop the interrupt.

The analog converter is replaced by a behavioural input port. The controller drives the channel it is converting on `conv_ch`, and the environment returns that channel's sample on `sample_in`. The sample is taken on the cycle the conversion finishes. Reads are combinational from `bus_addr`. A write lands on the rising clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset the control, channel and settle-delay registers read 0, the start bit reads 0 and `irq_o` is low.
- R2: Register byte offsets are control 0x00, settle-delay 0x08 (16 bits, read/write, no other effect), result 0x0C, acknowledge 0x18 and channel 0x1C (3 bits). In the control word, bit 0 is start, bit 2 is standby, bits [13:6] hold the divider value P, bit 14 enables the divider and bit 16 selects 12-bit results. Unimplemented bits and unmapped offsets read 0.
- R3: A control write with bit 0 set and bit 2 clear, made while idle, launches one conversion on the selected channel. The start bit reads 1 from the next cycle until the result is latched, then reads 0.
- R4: A control write with bit 2 (standby) set launches nothing, even when bit 0 is set.
- R5: With the divider enabled, the result and interrupt appear exactly (B+2)*(P+1) cycles after the launching write edge. B is 12 when bit 16 is set and 10 otherwise.
- R6: While the divider enable (bit 14) is clear, a launched conversion makes no progress and the start bit stays 1. Once the divider is enabled by a control write, the conversion completes (B+2)*(P+1) cycles after that write edge.
- R7: In 12-bit mode the result at 0x0C bits [11:0] equals the sample. In 10-bit mode it equals the sample's upper 10 bits in [9:0]. All other result bits read 0.
- R8: `irq_o` rises on the same cycle the result register updates. Any write to 0x18 lowers it. If that write coincides with a completion, the interrupt stays high.
- R9: A start request made while a conversion is in progress is ignored. The running conversion keeps its completion time and no second conversion follows.
- R10: The result register is not cleared by reset. It holds its value until the next completion.
- R11: The channel and result width are fixed when the conversion launches. Writes to the channel register or to bit 16 during a conversion do not change that conversion's channel, length or format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| conv_ch | output | 3 | Channel of the current or last conversion |
| sample_in | input | 12 | Behavioural sample of channel conv_ch |
| irq_o | output | 1 | Conversion-complete interrupt |

## Verification
Several properties are checked on every cycle: reset leaves the controller idle and quiet; a launch write makes it busy; a standby write does not; a busy conversion cannot end while the divider is off or before its final tick; and the interrupt rises only after a completion and falls after an acknowledge that does not coincide with one. The exact completion cycle for each divider value and width, the result value and its alignment, and the locking of the channel and width at launch can only be shown by the bench. The bench sweeps all channels, both widths and several divider values, and covers the acknowledge/completion collision and the result surviving reset.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 5;
    localparam int PRESC_W = 8;

    // byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DLY  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_CHAN = 5'h1C;

    // control word bit positions
    localparam int BIT_START = 0;
    localparam int BIT_STBY  = 2;
    localparam int BIT_PLO   = 6;
    localparam int BIT_PEN   = 14;
    localparam int BIT_RES   = 16;

    typedef struct packed {
        logic               res_hi;
        logic               pre_en;
        logic [PRESC_W-1:0] pre_val;
        logic               standby;
    } ctrl_t;

    typedef struct packed {
        logic go;
        logic res_hi;
    } launch_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    // number of divided ticks one conversion lasts
    function automatic int unsigned conv_ticks(input logic res_hi,
                                               input int unsigned hi_bits,
                                               input int unsigned lo_bits);
        return (res_hi ? hi_bits : lo_bits) + 2;
    endfunction

endpackage

// File: rtl/sar_conv_regs.sv
module sar_conv_regs
    import sar_conv_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] result,
    output ctrl_t             ctrl_q,
    output logic [CH_W-1:0]   chan_q,
    output launch_t           launch,
    output logic              ack_req,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic             wr_en;
    logic             hit_ctrl;
    logic             hit_dly;
    logic             hit_chan;
    logic [DLY_W-1:0] dly_q;
    ctrl_t            ctrl_d;
    logic             unused_wdata;

    assign wr_en    = bus_sel && bus_wr;
    assign hit_ctrl = wr_en && (bus_addr == OFS_CTRL);
    assign hit_dly  = wr_en && (bus_addr == OFS_DLY);
    assign hit_chan = wr_en && (bus_addr == OFS_CHAN);
    assign ack_req  = wr_en && (bus_addr == OFS_ACK);

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        ctrl_d.res_hi  = bus_wdata[BIT_RES];
        ctrl_d.pre_en  = bus_wdata[BIT_PEN];
        ctrl_d.pre_val = bus_wdata[BIT_PLO +: PRESC_W];
        ctrl_d.standby = bus_wdata[BIT_STBY];
    end

    // a launch request carries the width being written with it
    always_comb begin
        launch.go     = hit_ctrl && bus_wdata[BIT_START] && !bus_wdata[BIT_STBY];
        launch.res_hi = bus_wdata[BIT_RES];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            chan_q <= '0;
            dly_q  <= '0;
        end else begin
            if (hit_ctrl) ctrl_q <= ctrl_d;
            if (hit_chan) chan_q <= bus_wdata[CH_W-1:0];
            if (hit_dly)  dly_q  <= bus_wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_START]           = busy;
                bus_rdata[BIT_STBY]            = ctrl_q.standby;
                bus_rdata[BIT_PLO +: PRESC_W]  = ctrl_q.pre_val;
                bus_rdata[BIT_PEN]             = ctrl_q.pre_en;
                bus_rdata[BIT_RES]             = ctrl_q.res_hi;
            end
            OFS_DLY:  bus_rdata[DLY_W-1:0]  = dly_q;
            OFS_DATA: bus_rdata[DATA_W-1:0] = result;
            OFS_CHAN: bus_rdata[CH_W-1:0]   = chan_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sar_conv_div.sv
module sar_conv_div
    import sar_conv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PRESC_W-1:0] pre_val,
    output logic               tick
);

    logic [PRESC_W-1:0] cnt_q;

    assign tick = run && (cnt_q == pre_val);

    // counter restarts whenever the divider is stopped or wraps
    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_conv_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 12,
    parameter int LOW_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  logic              ack_req,
    input  logic              pre_en,
    input  logic              tick,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic              done,
    output seq_state_e        state,
    output logic [CH_W-1:0]   conv_ch,
    output logic [DATA_W-1:0] result,
    output logic              irq_o
);

    localparam int TCNT_W   = $clog2(DATA_W + 3);
    localparam int LEN_HI   = conv_ticks(1'b1, DATA_W, LOW_W);
    localparam int LEN_LO   = conv_ticks(1'b0, DATA_W, LOW_W);

    logic              active_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [TCNT_W-1:0] len_q;
    logic              res_q;
    logic [DATA_W-1:0] fmt_val;

    assign busy  = active_q;
    assign done  = active_q && tick && (tcnt_q == len_q - 1'b1);
    assign state = !active_q ? SEQ_IDLE : (pre_en ? SEQ_RUN : SEQ_HOLD);

    // result alignment chosen by the width locked at launch
    generate
        if (DATA_W > LOW_W) begin : g_narrow
            always_comb begin
                fmt_val = res_q ? sample_in
                                : {{(DATA_W-LOW_W){1'b0}}, sample_in[DATA_W-1 -: LOW_W]};
            end
        end else begin : g_full
            always_comb fmt_val = sample_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            tcnt_q   <= '0;
            len_q    <= '0;
            res_q    <= 1'b0;
            conv_ch  <= '0;
        end else if (!active_q) begin
            if (launch.go) begin
                active_q <= 1'b1;
                tcnt_q   <= '0;
                res_q    <= launch.res_hi;
                len_q    <= launch.res_hi ? TCNT_W'(LEN_HI) : TCNT_W'(LEN_LO);
                conv_ch  <= chan_sel;
            end
        end else if (tick) begin
            if (done) begin
                active_q <= 1'b0;
                tcnt_q   <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // result has no reset: it survives until overwritten
    always_ff @(posedge clk) begin
        if (done) result <= fmt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else if (done) begin
            irq_o <= 1'b1;
        end else if (ack_req) begin
            irq_o <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DLY_W  = 16,
    parameter int DATA_W = 12,
    parameter int LOW_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] sample_in,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    logic [CH_W-1:0]   chan_q;
    launch_t           launch;
    logic              ack_req;
    logic              conv_busy;
    logic              conv_done;
    logic              pre_en_w;
    logic              div_run;
    logic              div_tick;
    logic [DATA_W-1:0] result;
    seq_state_e        seq_state;

    assign pre_en_w = ctrl_q.pre_en;
    assign div_run  = conv_busy && pre_en_w;

    sar_conv_regs #(
        .CH_W   (CH_W),
        .DLY_W  (DLY_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (conv_busy),
        .result    (result),
        .ctrl_q    (ctrl_q),
        .chan_q    (chan_q),
        .launch    (launch),
        .ack_req   (ack_req),
        .bus_rdata (bus_rdata)
    );

    sar_conv_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (div_run),
        .pre_val (ctrl_q.pre_val),
        .tick    (div_tick)
    );

    sar_conv_seq #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ack_req   (ack_req),
        .pre_en    (pre_en_w),
        .tick      (div_tick),
        .chan_sel  (chan_q),
        .sample_in (sample_in),
        .busy      (conv_busy),
        .done      (conv_done),
        .state     (seq_state),
        .conv_ch   (conv_ch),
        .result    (result),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
    import sar_conv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              irq_o,
    input logic              busy,
    input logic              done,
    input logic              pre_en
);

    logic rst_seen = 1'b0;
    logic ctrl_wr;
    logic ack_wr;

    assign ctrl_wr = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign ack_wr  = bus_sel && bus_wr && (bus_addr == OFS_ACK);

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            AST_RESET_QUIET: assert (!busy && !irq_o); // R1
        end
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[BIT_START] && !bus_wdata[BIT_STBY] && !busy) |=> busy); // R3

    AST_STBY_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[BIT_STBY] && !busy) |=> !busy); // R4

    AST_HOLD_NO_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        (busy && !pre_en) |=> busy); // R6

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R9

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(done)); // R8

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !done) |=> !irq_o); // R8

endmodule

bind sar_conv_ctrl sar_conv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .busy      (conv_busy),
    .done      (conv_done),
    .pre_en    (pre_en_w)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_DLY  = 5'h08;
    localparam logic [4:0] A_DATA = 5'h0C;
    localparam logic [4:0] A_ACK  = 5'h18;
    localparam logic [4:0] A_CHAN = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  conv_ch;
    logic [11:0] sample_in;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] smp(input logic [2:0] ch);
        return 12'hA5C ^ {ch, ch, ch, ch};
    endfunction

    assign sample_in = smp(conv_ch);

    sar_conv_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .conv_ch   (conv_ch),
        .sample_in (sample_in),
        .irq_o     (irq_o)
    );

    function automatic logic [31:0] mk(input bit start, input bit stby, input int p,
                                       input bit en, input bit res);
        logic [31:0] w;
        w = '0;
        w[0] = start;
        w[2] = stby;
        w[13:6] = p[7:0];
        w[14] = en;
        w[16] = res;
        return w;
    endfunction

    function automatic logic [31:0] expv(input logic [2:0] ch, input bit res);
        return res ? {20'b0, smp(ch)} : {22'b0, smp(ch)[11:2]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_conv(input logic [2:0] ch, input bit res, input int p);
        logic [31:0] v;
        int len;
        len = (res ? 14 : 12) * (p + 1);
        bwrite(A_CHAN, {29'b0, ch});
        bwrite(A_CTRL, mk(1, 0, p, 1, res));
        wait_cyc(len - 1);
        bread(A_CTRL, v);
        chk("R5 start bit one cycle before end", {31'b0, v[0]}, 32'd1);
        chk("R8 irq low before completion", {31'b0, irq_o}, 32'd0);
        wait_cyc(1);
        chk("R8 irq high at completion", {31'b0, irq_o}, 32'd1);
        bread(A_DATA, v);
        chk("R7 result value", v, expv(ch, res));
        bread(A_CTRL, v);
        chk("R3 start bit clears", {31'b0, v[0]}, 32'd0);
        bwrite(A_ACK, 32'hDEAD_0000);
        chk("R8 ack lowers irq", {31'b0, irq_o}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog R1..R11 actual=%0d expected<%0d", cyc, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;

        wait_cyc(3);
        rst = 1'b0;

        // R1: reset state
        bread(A_CTRL, v); chk("R1 control after reset", v, 32'd0);
        bread(A_CHAN, v); chk("R1 channel after reset", v, 32'd0);
        bread(A_DLY, v);  chk("R1 delay after reset", v, 32'd0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'd0);

        // R2 + R4: all-ones write with standby set, readback masks
        bwrite(A_CTRL, 32'hFFFF_FFFF);
        bread(A_CTRL, v); chk("R2 control readback", v, 32'h0001_7FC4);
        wait_cyc(30);
        bread(A_CTRL, v); chk("R4 standby blocks start", {31'b0, v[0]}, 32'd0);
        chk("R4 no irq in standby", {31'b0, irq_o}, 32'd0);
        bwrite(A_DLY, 32'hFFFF_FFFF);
        bread(A_DLY, v); chk("R2 delay readback", v, 32'h0000_FFFF);
        bwrite(A_CHAN, 32'hFFFF_FFFF);
        bread(A_CHAN, v); chk("R2 channel readback", v, 32'h0000_0007);
        bread(5'h04, v); chk("R2 unmapped offset", v, 32'd0);
        bwrite(A_CTRL, 32'd0);

        // R5/R7/R8: sweep channels, widths, divider values
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            for (int r = 0; r < 2; r++) begin
                for (int ch = 0; ch < 8; ch++) begin
                    run_conv(3'(ch), bit'(r), p);
                end
            end
        end

        // R6: divider disabled holds the conversion pending
        bwrite(A_CHAN, 32'd6);
        bwrite(A_CTRL, mk(1, 0, 1, 0, 0));
        wait_cyc(40);
        bread(A_CTRL, v); chk("R6 pending start bit", {31'b0, v[0]}, 32'd1);
        chk("R6 no irq while held", {31'b0, irq_o}, 32'd0);
        bwrite(A_CTRL, mk(0, 0, 1, 1, 0));
        wait_cyc(23);
        bread(A_CTRL, v); chk("R6 busy before end", {31'b0, v[0]}, 32'd1);
        wait_cyc(1);
        chk("R6 irq after enable", {31'b0, irq_o}, 32'd1);
        bread(A_DATA, v); chk("R6 result", v, expv(3'd6, 1'b0));
        bwrite(A_ACK, 32'd0);

        // R11: channel and width locked at launch
        bwrite(A_CHAN, 32'd2);
        bwrite(A_CTRL, mk(1, 0, 0, 1, 1));
        wait_cyc(3);
        bwrite(A_CHAN, 32'd5);
        bwrite(A_CTRL, mk(0, 0, 0, 1, 0));
        wait_cyc(8);
        bread(A_CTRL, v); chk("R11 length kept", {31'b0, v[0]}, 32'd1);
        wait_cyc(1);
        chk("R11 irq at locked length", {31'b0, irq_o}, 32'd1);
        bread(A_DATA, v); chk("R11 channel and width kept", v, expv(3'd2, 1'b1));
        bwrite(A_ACK, 32'd0);

        // R9: restart while busy is ignored
        bwrite(A_CHAN, 32'd3);
        bwrite(A_CTRL, mk(1, 0, 0, 1, 1));
        wait_cyc(4);
        bwrite(A_CTRL, mk(1, 0, 0, 1, 1));
        wait_cyc(8);
        bread(A_CTRL, v); chk("R9 busy before original end", {31'b0, v[0]}, 32'd1);
        wait_cyc(1);
        chk("R9 completes on original time", {31'b0, irq_o}, 32'd1);
        bwrite(A_ACK, 32'd0);
        wait_cyc(30);
        bread(A_CTRL, v); chk("R9 no second conversion", {31'b0, v[0]}, 32'd0);
        chk("R9 no second irq", {31'b0, irq_o}, 32'd0);

        // R8: acknowledge colliding with completion
        bwrite(A_CHAN, 32'd1);
        bwrite(A_CTRL, mk(1, 0, 0, 1, 0));
        wait_cyc(11);
        bwrite(A_ACK, 32'd0);
        chk("R8 completion wins over ack", {31'b0, irq_o}, 32'd1);
        bread(A_DATA, held); chk("R8 result on collision", held, expv(3'd1, 1'b0));
        bwrite(A_ACK, 32'd0);
        chk("R8 later ack clears", {31'b0, irq_o}, 32'd0);

        // R10: result survives reset
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        bread(A_DATA, v); chk("R10 result kept over reset", v, held);
        bread(A_CTRL, v); chk("R1 control cleared by reset", v, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule